// File: doc/BRIEF.md
# Streaming Vector Element Shifter

This block shifts a stream of 64-bit vector elements at a rate of one element per clock. It has a fixed latency of four stages. Each vector enters as a run of elements on consecutive clocks, and the final element carries a last marker. The first element of the vector also carries a shift count, a direction and a mode. The block keeps these for the rest of the vector. In single mode each element is shifted on its own. In double mode each element is joined with the element after it into a 128-bit word, and that word is shifted. The element after the final one is taken to be zero.

The front end runs a small controller with two states. `ST_IDLE` waits for the first element of a vector. Taking a first element that is not also the last moves it to `ST_STREAM` (transition *open*). Taking the last element in `ST_STREAM` returns it to `ST_IDLE` (transition *close*). A one-element vector is taken and completed while the controller stays in `ST_IDLE` (transition *solo*). The front end then pairs each element with its neighbour. Two shift stages follow: the first moves the word by a multiple of eight bits and the second moves it by the remaining zero to seven bits. The last stage chooses which half of the 128-bit word to output. The results leave in the same order as the elements came in, one result for each element. Shifts are logical and fill with zeros, and there is no overflow indication.

Top module: `vec_elem_shifter`

## Requirements
- R1: While reset is held and after it is released, with no input, `res_valid` and `res_last` are 0.
- R2: An element accepted on a rising edge (`elem_valid`=1) produces a result that appears after the fourth rising edge, counting the accepting edge as the first. Results leave one per clock at the input rate, and the number of results equals the number of elements.
- R3: Single mode (`sh_mode`=0), left (`sh_dir`=0): the result is the element shifted left by `sh_count` with zero fill. A count of 64 or more gives 0.
- R4: Single mode, right (`sh_dir`=1): the result is the element shifted right by `sh_count` with zero fill. A count of 64 or more gives 0.
- R5: Double mode (`sh_mode`=1), left: the result is the upper 64 bits of {element i, element i+1} shifted left by `sh_count` (0 to 127).
- R6: Double mode, right: the result is the lower 64 bits of {element i, element i+1} shifted right by `sh_count`.
- R7: In double mode the final element of a vector is paired with a zero word as element i+1.
- R8: `res_last` is 1 only with the result of an element that was marked last.
- R9: The count, direction and mode are sampled with the first element of a vector. Their port values on later elements of the same vector have no effect.
- R10: The elements of a vector arrive on consecutive clocks. A new vector may start on the clock right after a last element, with a different configuration, and each vector keeps its own configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| elem_valid | input | 1 | Element present this clock |
| elem_last | input | 1 | Element is the final one of its vector |
| elem_data | input | 64 | Element value |
| sh_count | input | 7 | Shift distance, sampled with the first element |
| sh_dir | input | 1 | 0 left, 1 right, sampled with the first element |
| sh_mode | input | 1 | 0 single, 1 double, sampled with the first element |
| res_valid | output | 1 | Result present this clock |
| res_last | output | 1 | Result belongs to the final element |
| res_data | output | 64 | Shifted result |

## Verification
If the controller is left in the wrong state, the next vector uses stale or wrong configuration. That shows as wrong data on its first result, four clocks later. A pairing fault in double mode, such as a neighbour that is not cleared on the last element, corrupts the final result of a vector and can be seen at that result's slot. A fault in a shift stage shows as a bit pattern error on the very result it carries, and the count-boundary cases (0, 63, 64, 127) expose faults in slice or half selection. Mismatches in timing or marker alignment show up as a result arriving in an unexpected cycle or with the wrong last flag.

// File: rtl/vsh_pkg.sv
package vsh_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } fsm_e;

    localparam logic DIR_RIGHT   = 1'b1;
    localparam logic MODE_DOUBLE = 1'b1;
endpackage

// File: rtl/vsh_front.sv
module vsh_front
    import vsh_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_last,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [CNT_W-1:0]      in_cnt,
    input  logic                  in_dir,
    input  logic                  in_mode,
    output logic                  pr_valid,
    output logic                  pr_last,
    output logic                  pr_dir,
    output logic                  pr_mode,
    output logic [CNT_W-1:0]      pr_cnt,
    output logic [2*DATA_W-1:0]   pr_word
);
    localparam int WORD_W = 2 * DATA_W;

    fsm_e state, nxt;
    logic first_beat;

    logic [CNT_W-1:0] hold_cnt;
    logic             hold_dir, hold_mode;
    logic [CNT_W-1:0] sel_cnt;
    logic             sel_dir, sel_mode;

    logic              s1_valid, s1_last, s1_first, s1_dir, s1_mode;
    logic [CNT_W-1:0]  s1_cnt;
    logic [DATA_W-1:0] s1_data;
    logic [DATA_W-1:0] partner;
    logic [WORD_W-1:0] pair_word;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state: open, close, solo
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (in_valid && !in_last) nxt = ST_STREAM;
            ST_STREAM: if (in_valid && in_last)  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // controller outputs
    always_comb begin
        first_beat = 1'b0;
        unique case (state)
            ST_IDLE:   first_beat = in_valid;
            ST_STREAM: first_beat = 1'b0;
            default:   first_beat = 1'b0;
        endcase
        sel_cnt  = first_beat ? in_cnt  : hold_cnt;
        sel_dir  = first_beat ? in_dir  : hold_dir;
        sel_mode = first_beat ? in_mode : hold_mode;
    end

    // configuration held for the rest of the vector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt  <= '0;
            hold_dir  <= 1'b0;
            hold_mode <= 1'b0;
        end else if (first_beat) begin
            hold_cnt  <= in_cnt;
            hold_dir  <= in_dir;
            hold_mode <= in_mode;
        end
    end

    // stage 1: capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_last  <= 1'b0;
            s1_first <= 1'b0;
            s1_dir   <= 1'b0;
            s1_mode  <= 1'b0;
            s1_cnt   <= '0;
            s1_data  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_last  <= in_valid && in_last;
            s1_first <= first_beat;
            s1_dir   <= sel_dir;
            s1_mode  <= sel_mode;
            s1_cnt   <= sel_cnt;
            s1_data  <= in_data;
        end
    end

    // stage 2: pairing with the following element
    always_comb begin
        partner = s1_last ? '0 : in_data;
        if (s1_mode == MODE_DOUBLE)   pair_word = {s1_data, partner};
        else if (s1_dir == DIR_RIGHT) pair_word = {{DATA_W{1'b0}}, s1_data};
        else                          pair_word = {s1_data, {DATA_W{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_valid <= 1'b0;
            pr_last  <= 1'b0;
            pr_dir   <= 1'b0;
            pr_mode  <= 1'b0;
            pr_cnt   <= '0;
            pr_word  <= '0;
        end else begin
            pr_valid <= s1_valid;
            pr_last  <= s1_last;
            pr_dir   <= s1_dir;
            pr_mode  <= s1_mode;
            pr_cnt   <= s1_cnt;
            pr_word  <= pair_word;
        end
    end

    AST_GAPLESS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM) |-> in_valid); // R10

    AST_CFG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_first) |-> (s1_cnt == $past(s1_cnt) && s1_dir == $past(s1_dir)
                                     && s1_mode == $past(s1_mode))); // R9

    AST_TAIL_PARTNER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_valid && pr_last && pr_mode == MODE_DOUBLE) |-> (pr_word[DATA_W-1:0] == '0)); // R7
endmodule

// File: rtl/vsh_shift_stage.sv
module vsh_shift_stage #(
    parameter int WORD_W = 128,
    parameter int CNT_W  = 7,
    parameter int LO     = 3,
    parameter int HI     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_valid,
    input  logic              i_last,
    input  logic              i_dir,
    input  logic              i_mode,
    input  logic [CNT_W-1:0]  i_cnt,
    input  logic [WORD_W-1:0] i_word,
    output logic              o_valid,
    output logic              o_last,
    output logic              o_dir,
    output logic              o_mode,
    output logic [CNT_W-1:0]  o_cnt,
    output logic [WORD_W-1:0] o_word
);
    logic [CNT_W-1:0]  amt;
    logic [WORD_W-1:0] moved;

    always_comb begin
        amt   = CNT_W'(i_cnt[HI:LO]) << LO;
        moved = i_dir ? (i_word >> amt) : (i_word << amt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_last  <= 1'b0;
            o_dir   <= 1'b0;
            o_mode  <= 1'b0;
            o_cnt   <= '0;
            o_word  <= '0;
        end else begin
            o_valid <= i_valid;
            o_last  <= i_last;
            o_dir   <= i_dir;
            o_mode  <= i_mode;
            o_cnt   <= i_cnt;
            o_word  <= moved;
        end
    end
endmodule

// File: rtl/vec_elem_shifter.sv
module vec_elem_shifter
    import vsh_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int FINE_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       elem_valid,
    input  logic                       elem_last,
    input  logic [DATA_W-1:0]          elem_data,
    input  logic [$clog2(2*DATA_W)-1:0] sh_count,
    input  logic                       sh_dir,
    input  logic                       sh_mode,
    output logic                       res_valid,
    output logic                       res_last,
    output logic [DATA_W-1:0]          res_data
);
    localparam int WORD_W = 2 * DATA_W;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam int N_SH   = 2;

    logic [N_SH:0]     c_valid, c_last, c_dir, c_mode;
    logic [CNT_W-1:0]  c_cnt  [N_SH+1];
    logic [WORD_W-1:0] c_word [N_SH+1];

    vsh_front #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (elem_valid),
        .in_last  (elem_last),
        .in_data  (elem_data),
        .in_cnt   (sh_count),
        .in_dir   (sh_dir),
        .in_mode  (sh_mode),
        .pr_valid (c_valid[0]),
        .pr_last  (c_last[0]),
        .pr_dir   (c_dir[0]),
        .pr_mode  (c_mode[0]),
        .pr_cnt   (c_cnt[0]),
        .pr_word  (c_word[0])
    );

    // stage 0 moves by multiples of 2**FINE_W, stage 1 by the remainder
    for (genvar g = 0; g < N_SH; g++) begin : g_shift
        localparam int SL_LO = (g == 0) ? FINE_W : 0;
        localparam int SL_HI = (g == 0) ? CNT_W - 1 : FINE_W - 1;
        vsh_shift_stage #(.WORD_W(WORD_W), .CNT_W(CNT_W), .LO(SL_LO), .HI(SL_HI)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .i_valid (c_valid[g]),
            .i_last  (c_last[g]),
            .i_dir   (c_dir[g]),
            .i_mode  (c_mode[g]),
            .i_cnt   (c_cnt[g]),
            .i_word  (c_word[g]),
            .o_valid (c_valid[g+1]),
            .o_last  (c_last[g+1]),
            .o_dir   (c_dir[g+1]),
            .o_mode  (c_mode[g+1]),
            .o_cnt   (c_cnt[g+1]),
            .o_word  (c_word[g+1])
        );
    end

    always_comb begin
        res_valid = c_valid[N_SH];
        res_last  = c_last[N_SH];
        res_data  = (c_dir[N_SH] == DIR_RIGHT) ? c_word[N_SH][DATA_W-1:0]
                                               : c_word[N_SH][WORD_W-1:DATA_W];
    end

    AST_FOUR_STAGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid |-> ##4 res_valid); // R2

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_last |-> res_valid); // R8

    AST_SINGLE_WIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && c_mode[N_SH] != MODE_DOUBLE && c_cnt[N_SH] >= CNT_W'(DATA_W))
        |-> (res_data == '0)); // R3
endmodule

// File: tb/vec_elem_shifter_tb.sv
module vec_elem_shifter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        elem_valid = 1'b0, elem_last = 1'b0;
    logic [63:0] elem_data = '0;
    logic [6:0]  sh_count = '0;
    logic        sh_dir = 1'b0, sh_mode = 1'b0;
    logic        res_valid, res_last;
    logic [63:0] res_data;

    vec_elem_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .elem_valid(elem_valid), .elem_last(elem_last),
        .elem_data(elem_data), .sh_count(sh_count), .sh_dir(sh_dir), .sh_mode(sh_mode),
        .res_valid(res_valid), .res_last(res_last), .res_data(res_data)
    );

    always #4 clk = ~clk; // 125 MHz

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [63:0] exp_data [0:4095];
    logic        exp_last [0:4095];
    int          exp_cyc  [0:4095];
    string       exp_tag  [0:4095];
    int wr = 0, rd = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [63:0] ref_shift(input logic [63:0] a, input logic [63:0] b,
                                              input int c, input bit dir, input bit mode);
        logic [127:0] w;
        if (!mode) begin
            if (c >= 64) return 64'h0;
            return dir ? (a >> c) : (a << c);
        end
        w = {a, b};
        if (dir) begin w = w >> c; return w[63:0]; end
        w = w << c;
        return w[127:64];
    endfunction

    // mode/tag: garble=1 drives random config on later elements (R9), b2b marks R10
    task automatic send_vec(input int len, input int c, input bit dir, input bit mode,
                            input bit garble, input bit b2b);
        logic [63:0] el [0:15];
        for (int i = 0; i < len; i++) el[i] = {$urandom, $urandom};
        for (int i = 0; i < len; i++) begin
            logic [63:0] nb;
            string t;
            nb = (i == len - 1) ? 64'h0 : el[i+1];
            exp_data[wr] = ref_shift(el[i], nb, c, dir, mode);
            exp_last[wr] = (i == len - 1);
            if (mode && i == len - 1)  t = "R7";
            else if (garble)          t = "R9";
            else if (b2b)             t = "R10";
            else if (mode)            t = dir ? "R6" : "R5";
            else                      t = dir ? "R4" : "R3";
            exp_tag[wr] = t;
            @(negedge clk);
            exp_cyc[wr] = cyc + 4;
            wr++;
            elem_valid = 1'b1;
            elem_data  = el[i];
            elem_last  = (i == len - 1);
            if (i == 0 || !garble) begin
                sh_count = 7'(c); sh_dir = dir; sh_mode = mode;
            end else begin
                sh_count = 7'($urandom); sh_dir = 1'($urandom); sh_mode = 1'($urandom);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            elem_valid = 1'b0;
            elem_last  = 1'b0;
            elem_data  = {$urandom, $urandom};
            sh_count   = 7'($urandom);
        end
    endtask

    // result monitor
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (rd >= wr) begin
                chk(1'b0, "R2 unexpected result", {63'h0, res_valid}, 64'h0);
            end else begin
                chk(res_data == exp_data[rd], exp_tag[rd], res_data, exp_data[rd]);
                chk(res_last == exp_last[rd], "R8", {63'h0, res_last}, {63'h0, exp_last[rd]});
                chk(cyc == exp_cyc[rd], "R2 timing", 64'(cyc), 64'(exp_cyc[rd]));
                rd++;
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R2 actual=%h expected=%h", rd, wr);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0 && res_last == 1'b0, "R1 in reset", {62'h0, res_valid, res_last}, 64'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0 && res_last == 1'b0, "R1 after reset", {62'h0, res_valid, res_last}, 64'h0);

        // directed corners
        send_vec(4, 0,   1'b0, 1'b0, 1'b0, 1'b0); idle(2);
        send_vec(3, 63,  1'b1, 1'b0, 1'b0, 1'b0); idle(1);
        send_vec(3, 64,  1'b0, 1'b0, 1'b0, 1'b0); idle(1);
        send_vec(3, 100, 1'b1, 1'b0, 1'b0, 1'b0); idle(1);
        send_vec(1, 5,   1'b0, 1'b1, 1'b0, 1'b0); idle(1);
        send_vec(1, 5,   1'b1, 1'b1, 1'b0, 1'b0); idle(1);
        send_vec(5, 127, 1'b0, 1'b1, 1'b0, 1'b0); idle(1);
        send_vec(5, 0,   1'b1, 1'b1, 1'b0, 1'b0); idle(1);
        send_vec(4, 64,  1'b1, 1'b1, 1'b0, 1'b0); idle(1);
        send_vec(6, 17,  1'b0, 1'b1, 1'b1, 1'b0); idle(1);
        // back-to-back vectors with different configurations
        send_vec(3, 9,   1'b0, 1'b1, 1'b0, 1'b1);
        send_vec(2, 70,  1'b1, 1'b0, 1'b0, 1'b1);
        send_vec(1, 33,  1'b1, 1'b1, 1'b0, 1'b1);
        send_vec(4, 1,   1'b0, 1'b0, 1'b0, 1'b1); idle(3);

        // constrained random vectors
        for (int v = 0; v < 300; v++) begin
            send_vec(1 + ($urandom % 12), $urandom % 128, 1'($urandom), 1'($urandom),
                     ($urandom % 4) == 0, 1'b0);
            idle($urandom % 3);
        end
        idle(8);
        chk(rd == wr, "R2 result count", 64'(rd), 64'(wr));
        finish_run();
    end
endmodule